// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Collector

This block gathers 32 external interrupt request lines into one sticky pending word. Each line passes through a two-flop synchroniser and a per-source polarity correction. It is then sensed either as a level or as a single transition, as its trigger bit selects. Pending bits stay set until software clears them by writing ones. The pending word is ANDed with an enable word to form a masked word. A critical-select word splits the masked word between two registered request lines: a critical one and a non-critical one.

Software reaches the six registers through a simple synchronous port. A write is taken on the clock edge where `reg_wr` is high. Read data is registered and always reflects the register addressed on the previous edge. Source numbering runs from the most significant bit down: source n lives at bit 31−n of every register and of the input bus.

A level-sensed source is re-latched on every cycle in which its input is active. A clear aimed at it therefore has no effect until the device drops its request, whether the source is enabled or not.

Top module: `irq_ctrl32`

## Requirements
- R1: After reset, pending, enable, critical-select and trigger registers read 0, polarity reads 32'hFFFF_FFFF, and both request outputs are low.
- R2: Source n occupies bit 31−n of `irq_in` and of every register, so source 0 is bit 31.
- R3: With trigger bit 0 (level), an active input sets its pending bit on the third rising edge after it changes (two synchroniser stages plus the pending register), and the bit stays set while the input remains active.
- R4: With trigger bit 1 (edge), one selected transition sets the pending bit once; the bit stays set after the input returns, and a clear while the input is held steady clears it.
- R5: Polarity bit 1 selects active-high level or rising edge; polarity bit 0 selects active-low level or falling edge.
- R6: Writing the pending register (address 0) clears every bit written as 1 and leaves bits written as 0 unchanged; a pending bit never clears without such a write.
- R7: A clear of a level-sensed pending bit whose input is still active has no effect, whether or not the source is enabled.
- R8: When a set and a clear of the same pending bit fall on the same edge, the bit ends up set.
- R9: The masked register (address 5) reads pending AND enable, reads 0 when nothing enabled is pending, and ignores writes.
- R10: `irq_noncrit` is the OR of masked bits whose critical-select bit is 0 and `irq_crit` is the OR of those whose bit is 1; each follows one edge after the pending, enable or critical-select change.
- R11: Addresses are 0 pending, 1 enable, 2 critical-select, 3 trigger, 4 polarity, 5 masked; `reg_rdata` shows the register addressed at the previous edge, addresses 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous requests, source n at bit 31−n |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_noncrit | output | 1 | Registered non-critical request |
| irq_crit | output | 1 | Registered critical request |

## Verification
An input change shows in the pending register three edges later. It reaches a request output one edge after that. A register write takes effect on the edge it is presented at. Read data appears one edge after the address is set. Every expected item is queued with the cycle in which it becomes due, derived from these latencies. The monitor compares it on the falling edge of that cycle only. The stimulus waits long enough after each input change before it queues a read, and sets the same-edge set/clear collision by counting these stages exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 32;
    localparam int AW   = 3;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef enum logic [AW-1:0] {
        RA_PEND  = 3'd0,
        RA_ENAB  = 3'd1,
        RA_CRIT  = 3'd2,
        RA_TRIG  = 3'd3,
        RA_POL   = 3'd4,
        RA_MASKD = 3'd5
    } reg_addr_e;

    typedef struct packed {
        srcvec_t enab;
        srcvec_t crit;
        srcvec_t trig;
        srcvec_t pol;
    } cfg_t;

    typedef struct packed {
        logic            wr;
        logic [AW-1:0]   addr;
        srcvec_t         data;
    } bus_req_t;

    localparam srcvec_t POL_RESET = '1;

    function automatic srcvec_t src_bit(input int n);
        return srcvec_t'(1) << (NSRC - 1 - n);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_sense.sv
module irqc_sense
    import irqc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t sync_in,
    input  srcvec_t trig,
    input  srcvec_t pol,
    output srcvec_t active,
    output srcvec_t set_vec
);
    srcvec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= active;
    end

    for (genvar b = 0; b < NSRC; b++) begin : g_src
        always_comb begin
            active[b]  = ~(sync_in[b] ^ pol[b]);
            set_vec[b] = trig[b] ? (active[b] & ~prev_q[b]) : active[b];
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  srcvec_t  set_vec,
    output cfg_t     cfg,
    output srcvec_t  pend,
    output srcvec_t  masked,
    output srcvec_t  rdata
);
    srcvec_t clr_vec;

    always_comb begin
        clr_vec = '0;
        if (req.wr && reg_addr_e'(req.addr) == RA_PEND) clr_vec = req.data;
    end

    assign masked = pend & cfg.enab;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            cfg.enab <= '0;
            cfg.crit <= '0;
            cfg.trig <= '0;
            cfg.pol  <= POL_RESET;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
            if (req.wr) begin
                case (reg_addr_e'(req.addr))
                    RA_ENAB: cfg.enab <= req.data;
                    RA_CRIT: cfg.crit <= req.data;
                    RA_TRIG: cfg.trig <= req.data;
                    RA_POL:  cfg.pol  <= req.data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else begin
            case (reg_addr_e'(req.addr))
                RA_PEND:  rdata <= pend;
                RA_ENAB:  rdata <= cfg.enab;
                RA_CRIT:  rdata <= cfg.crit;
                RA_TRIG:  rdata <= cfg.trig;
                RA_POL:   rdata <= cfg.pol;
                RA_MASKD: rdata <= masked;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_outs.sv
module irqc_outs
    import irqc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t masked,
    input  srcvec_t crit,
    output logic    req_noncrit,
    output logic    req_crit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_noncrit <= 1'b0;
            req_crit    <= 1'b0;
        end else begin
            req_noncrit <= |(masked & ~crit);
            req_crit    <= |(masked & crit);
        end
    end
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_noncrit,
    output logic            irq_crit
);
    srcvec_t  sync_w;
    srcvec_t  active_w;
    srcvec_t  set_w;
    srcvec_t  pend_w;
    srcvec_t  masked_w;
    cfg_t     cfg_w;
    bus_req_t req_w;

    assign req_w.wr   = reg_wr;
    assign req_w.addr = reg_addr;
    assign req_w.data = reg_wdata;

    irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(irq_in), .dout(sync_w)
    );

    irqc_sense u_sense (
        .clk(clk), .rst(rst), .sync_in(sync_w),
        .trig(cfg_w.trig), .pol(cfg_w.pol),
        .active(active_w), .set_vec(set_w)
    );

    irqc_regs u_regs (
        .clk(clk), .rst(rst), .req(req_w), .set_vec(set_w),
        .cfg(cfg_w), .pend(pend_w), .masked(masked_w), .rdata(reg_rdata)
    );

    irqc_outs u_outs (
        .clk(clk), .rst(rst), .masked(masked_w), .crit(cfg_w.crit),
        .req_noncrit(irq_noncrit), .req_crit(irq_crit)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_wr,
    input logic [NSRC-1:0] reg_wdata,
    input logic [NSRC-1:0] reg_rdata,
    input logic            irq_noncrit,
    input logic            irq_crit,
    input srcvec_t         pend,
    input srcvec_t         enab,
    input srcvec_t         crit,
    input srcvec_t         trig,
    input srcvec_t         active,
    input srcvec_t         set_vec
);
    srcvec_t clr_w;
    srcvec_t hold_w;
    assign clr_w  = (reg_wr && reg_addr == 3'd0) ? reg_wdata : '0;
    assign hold_w = ~trig & active;

    // R1: outputs low after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_noncrit && !irq_crit));

    // R6: a pending bit only falls when a write-one clear names it
    p_no_silent_clear_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr_w)) == '0));

    // R7: a level source still active stays pending across any clear
    p_level_holds_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(hold_w)) == $past(hold_w)));

    // R8: a detected set always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R10: outputs track the split masked word one edge later
    p_noncrit_or_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_noncrit == |($past(pend) & $past(enab) & ~$past(crit))));
    p_crit_or_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_crit == |($past(pend) & $past(enab) & $past(crit))));

    // R11: unused addresses read zero
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr >= 3'd6) |=> (reg_rdata == '0));
endmodule

bind irq_ctrl32 irqc_checker u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_noncrit(irq_noncrit), .irq_crit(irq_crit),
    .pend(pend_w), .enab(cfg_w.enab), .crit(cfg_w.crit),
    .trig(cfg_w.trig), .active(active_w), .set_vec(set_w)
);

// File: tb/sim_irq_ctrl32.sv
module sim_irq_ctrl32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [2:0] A_PEND = 3'd0, A_ENAB = 3'd1, A_CRIT = 3'd2,
                           A_TRIG = 3'd3, A_POL  = 3'd4, A_MASKD = 3'd5;
    localparam int K_RD = 0, K_NC = 1, K_CR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_noncrit, irq_crit;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    irq_ctrl32 u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_noncrit(irq_noncrit), .irq_crit(irq_crit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] sb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    // monitor: compare each queued item on the falling edge it falls due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = reg_rdata;
                K_NC:    act = {31'b0, irq_noncrit};
                default: act = {31'b0, irq_crit};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.due = cyc + 1; it.kind = K_RD; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_out(input logic nc, input logic cr, input string tag);
        item_t it;
        it.due = cyc + 1; it.kind = K_NC; it.exp = {31'b0, nc}; it.tag = tag;
        sb_q.push_back(it);
        it.kind = K_CR; it.exp = {31'b0, cr};
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        idle(5);
        rst = 1'b0;
        idle(1);

        // R1 reset values
        exp_rd(A_PEND, 32'h0, "R1 pending");
        exp_rd(A_ENAB, 32'h0, "R1 enable");
        exp_rd(A_CRIT, 32'h0, "R1 critical");
        exp_rd(A_TRIG, 32'h0, "R1 trigger");
        exp_rd(A_POL, 32'hFFFF_FFFF, "R1 polarity");
        exp_out(1'b0, 1'b0, "R1 outputs");

        // R3/R2: level high on source 0 -> bit 31, third edge
        irq_in[31] = 1'b1;
        idle(1);
        exp_rd(A_PEND, 32'h0, "R3 not yet after two edges");
        idle(1);
        exp_rd(A_PEND, sb(0), "R2 R3 source 0 at bit 31");
        exp_rd(A_MASKD, 32'h0, "R9 masked zero when disabled");
        exp_out(1'b0, 1'b0, "R10 disabled source silent");

        // R10: enable -> non-critical output
        wr(A_ENAB, sb(0));
        idle(1);
        exp_rd(A_MASKD, sb(0), "R9 masked follows enable");
        exp_out(1'b1, 1'b0, "R10 noncritical raised");

        // R7: clear while level active, enabled and disabled
        wr(A_PEND, sb(0));
        exp_rd(A_PEND, sb(0), "R7 clear ignored enabled");
        wr(A_ENAB, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        exp_rd(A_PEND, sb(0), "R7 clear ignored masked");
        irq_in[31] = 1'b0;
        idle(4);
        exp_rd(A_PEND, sb(0), "R3 level stays sticky after drop");
        wr(A_PEND, 32'h0);
        exp_rd(A_PEND, sb(0), "R6 zero write leaves bit");
        wr(A_PEND, sb(0));
        exp_rd(A_PEND, 32'h0, "R6 one write clears");

        // R4/R10: rising edge on source 5, critical
        wr(A_TRIG, sb(5));
        wr(A_ENAB, sb(5));
        wr(A_CRIT, sb(5));
        irq_in[26] = 1'b1;
        idle(5);
        exp_rd(A_PEND, sb(5), "R4 rising edge latched");
        exp_out(1'b0, 1'b1, "R10 critical raised");
        wr(A_PEND, sb(5));
        idle(3);
        exp_rd(A_PEND, 32'h0, "R4 held high does not re-set");
        exp_out(1'b0, 1'b0, "R10 critical dropped");

        // R8: set and clear on the same edge
        irq_in[26] = 1'b0;
        idle(4);
        irq_in[26] = 1'b1;
        idle(2);
        wr(A_PEND, sb(5));
        exp_rd(A_PEND, sb(5), "R8 set beats clear");
        wr(A_PEND, sb(5));
        exp_rd(A_PEND, 32'h0, "R8 later clear works");

        // R5: falling edge on source 8 (bit 23)
        irq_in[23] = 1'b1;
        wr(A_TRIG, sb(5) | sb(8));
        wr(A_POL, ~sb(8));
        idle(4);
        wr(A_PEND, 32'hFFFF_FFFF);
        exp_rd(A_PEND, 32'h0, "R5 no edge while high");
        irq_in[23] = 1'b0;
        idle(4);
        exp_rd(A_PEND, sb(8), "R5 falling edge latched");
        wr(A_PEND, sb(8));

        // R5: active-low level on source 9 (bit 22)
        wr(A_POL, ~(sb(8) | sb(9)));
        idle(4);
        exp_rd(A_PEND, sb(9), "R5 active-low level");
        irq_in[22] = 1'b1;
        idle(4);
        wr(A_PEND, sb(9));
        exp_rd(A_PEND, 32'h0, "R5 released low level clears");

        // R9/R11: read-only masked, unused addresses
        wr(A_MASKD, 32'hFFFF_FFFF);
        exp_rd(A_ENAB, sb(5), "R9 masked write no effect on enable");
        exp_rd(A_MASKD, 32'h0, "R9 masked write ignored");
        wr(3'd7, 32'hFFFF_FFFF);
        exp_rd(3'd6, 32'h0, "R11 address 6 reads zero");
        exp_rd(3'd7, 32'h0, "R11 address 7 reads zero");
        exp_rd(A_CRIT, sb(5), "R11 critical address");
        exp_rd(A_TRIG, sb(5) | sb(8), "R11 trigger address");

        // R10: two level sources split across both outputs
        wr(A_POL, 32'hFFFF_FFFF);
        wr(A_TRIG, 32'h0);
        irq_in[22] = 1'b0;
        irq_in[23] = 1'b0;
        irq_in[26] = 1'b0;
        wr(A_CRIT, sb(31));
        wr(A_ENAB, sb(31) | sb(16));
        irq_in[0]  = 1'b1;
        irq_in[15] = 1'b1;
        idle(5);
        exp_rd(A_MASKD, sb(31) | sb(16), "R9 R2 two sources masked");
        exp_out(1'b1, 1'b1, "R10 both outputs");
        wr(A_ENAB, sb(16));
        idle(1);
        exp_out(1'b1, 1'b0, "R10 critical source masked off");

        idle(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule